// File: doc/BRIEF.md
# Serial CRC Generator and Checker

This block computes a cyclic redundancy check one bit per clock using a shift register with XOR feedback. The divisor polynomial and its degree are parameters. The register is as wide as the check sequence. An XOR gate sits only at the positions where the polynomial has a term, leaving out the constant term and the top term. All arithmetic is modulo 2, so adding and subtracting are both XOR.

In generate mode the block takes a message most significant bit first. It forms the remainder of that message, shifted left by the check width and divided by the polynomial. After the last message bit it shifts that remainder out serially, MSB first, with a valid strobe. The sender appends these bits to the message.

In check mode the block takes a whole received frame, the message followed by its check bits, through the same register. One clock after the last frame bit it reports a done pulse and an error flag. The flag is set when the remainder is not zero.

Top module: `crc_serial_unit`

## Requirements
- R1: After reset the remainder register is zero and fcs_valid, crc_error and check_done are all low.
- R2: A start pulse clears the remainder to zero, so bits taken before it have no effect on the next result. If bit_valid is high in the same clock, that bit is processed on the cleared register.
- R3: The remainder advances only on clocks where bit_valid is high. Idle clocks between message bits do not change the result.
- R4: In generate mode (mode_check = 0), the check sequence equals the modulo-2 remainder of the message times 2^FCS_W, divided by POLY. With the default POLY 110101, the message 1010001101 gives 01110.
- R5: The check sequence starts on fcs_bit in the clock after the bit carrying msg_end, MSB first. fcs_valid is high for exactly FCS_W clocks and low afterwards.
- R6: While the check sequence is being shifted out, bit_valid and bit_in are ignored unless start is also high.
- R7: In check mode (mode_check = 1), an error-free frame gives check_done high for exactly one clock, in the clock after the msg_end bit, with crc_error low.
- R8: In check mode, a frame hit by a single-bit error, or by a burst of FCS_W bits or fewer, sets crc_error in the clock that check_done is high.
- R9: crc_error holds its value until the next start pulse, and that pulse clears it.
- R10: The polynomial is a parameter. The block works the same with the degree-12 polynomial x^12+x^11+x^3+x+1 (POLY = 1100000001011).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Start of message or frame; clears the remainder and the error flag |
| bit_valid | input | 1 | bit_in carries a data bit this clock |
| bit_in | input | 1 | Serial data, MSB first |
| msg_end | input | 1 | Marks the valid bit as the last one of the message or frame |
| mode_check | input | 1 | 0 = generate, 1 = check; sampled with msg_end |
| fcs_bit | output | 1 | Serial check sequence, MSB first |
| fcs_valid | output | 1 | fcs_bit is valid |
| crc_error | output | 1 | Nonzero remainder found at the end of a checked frame |
| check_done | output | 1 | One-clock pulse when a check result is ready |

## Verification
The bench builds two copies of the block side by side. One uses the default degree-5 polynomial, which makes the worked example 1010001101 → 01110 a direct check. The other uses the degree-12 polynomial x^12+x^11+x^3+x+1, which exercises a wide register with sparse taps and a shift-out of twelve clocks. Expected remainders come from a long-division model in the bench. The tests cover bit gaps, ignored bits during shift-out, single-bit and burst corruption up to each degree, and clearing of the error flag.

// File: rtl/crc_pkg.sv
package crc_pkg;

  // Sequencer phase: accepting data bits, or emitting the check sequence
  typedef enum logic {
    PH_TAKE = 1'b0,
    PH_EMIT = 1'b1
  } crc_phase_e;

endpackage

// File: rtl/crc_div_stage.sv
// One modulo-2 long-division step: folds din_i into the remainder.
module crc_div_stage #(
  parameter int               W    = 5,
  parameter logic [W:0]       POLY = 6'b110101
) (
  input  logic [W-1:0] rem_i,
  input  logic         din_i,
  output logic [W-1:0] nxt_o
);

  logic fb;

  assign fb = rem_i[W-1] ^ din_i;

  // A gate only where the polynomial has a term below the top one;
  // the constant term is always present, so bit 0 takes feedback directly.
  for (genvar i = 0; i < W; i++) begin : g_bit
    if (i == 0) begin : g_lsb
      assign nxt_o[0] = fb;
    end else if (POLY[i]) begin : g_tap
      assign nxt_o[i] = rem_i[i-1] ^ fb;
    end else begin : g_pass
      assign nxt_o[i] = rem_i[i-1];
    end
  end

endmodule

// File: rtl/crc_seq_ctrl.sv
// Phase sequencer: accepts bits, then emits W check bits in generate mode.
module crc_seq_ctrl
  import crc_pkg::*;
#(
  parameter int W = 5
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic bit_valid,
  input  logic msg_end,
  input  logic mode_check,
  output logic accept,
  output logic fin_gen,
  output logic fin_chk,
  output logic emitting,
  output logic shift_en
);

  localparam int CW = $clog2(W + 1);

  crc_phase_e      ph_q;
  logic [CW-1:0]   cnt_q;

  assign accept   = bit_valid && (start || ph_q == PH_TAKE);
  assign fin_gen  = accept && msg_end && !mode_check;
  assign fin_chk  = accept && msg_end && mode_check;
  assign emitting = (ph_q == PH_EMIT);
  assign shift_en = emitting && !start;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q  <= PH_TAKE;
      cnt_q <= '0;
    end else if (fin_gen) begin
      ph_q  <= PH_EMIT;
      cnt_q <= CW'(W - 1);
    end else if (start) begin
      ph_q  <= PH_TAKE;
      cnt_q <= '0;
    end else if (ph_q == PH_EMIT) begin
      if (cnt_q == '0) begin
        ph_q <= PH_TAKE;
      end else begin
        cnt_q <= cnt_q - 1'b1;
      end
    end
  end

endmodule

// File: rtl/crc_serial_unit.sv
module crc_serial_unit #(
  parameter int          FCS_W = 5,
  parameter logic [FCS_W:0] POLY = 6'b110101
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic bit_valid,
  input  logic bit_in,
  input  logic msg_end,
  input  logic mode_check,
  output logic fcs_bit,
  output logic fcs_valid,
  output logic crc_error,
  output logic check_done
);

  logic [FCS_W-1:0] rem_q;
  logic [FCS_W-1:0] div_base;
  logic [FCS_W-1:0] div_next;
  logic accept, fin_gen, fin_chk, emitting, shift_en;

  crc_seq_ctrl #(.W(FCS_W)) seq_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .bit_valid  (bit_valid),
    .msg_end    (msg_end),
    .mode_check (mode_check),
    .accept     (accept),
    .fin_gen    (fin_gen),
    .fin_chk    (fin_chk),
    .emitting   (emitting),
    .shift_en   (shift_en)
  );

  // Start clears the register before the division step sees it
  assign div_base = start ? '0 : rem_q;

  crc_div_stage #(.W(FCS_W), .POLY(POLY)) div_i (
    .rem_i (div_base),
    .din_i (bit_in),
    .nxt_o (div_next)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem_q <= '0;
    end else if (accept) begin
      rem_q <= div_next;
    end else if (start) begin
      rem_q <= '0;
    end else if (shift_en) begin
      rem_q <= rem_q << 1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      crc_error  <= 1'b0;
      check_done <= 1'b0;
    end else begin
      check_done <= fin_chk;
      if (fin_chk) begin
        crc_error <= |div_next;
      end else if (start) begin
        crc_error <= 1'b0;
      end
    end
  end

  assign fcs_valid = emitting;
  assign fcs_bit   = emitting & rem_q[FCS_W-1];

endmodule

// File: rtl/crc_serial_unit_chk.sv
module crc_serial_unit_chk #(
  parameter int W = 5
) (
  input logic         clk,
  input logic         rst_n,
  input logic         start,
  input logic         bit_valid,
  input logic         fcs_valid,
  input logic         crc_error,
  input logic         check_done,
  input logic [W-1:0] rem_q
);

  localparam int RW = $clog2(W + 2) + 1;
  logic [RW-1:0] run_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           run_q <= '0;
    else if (start)       run_q <= '0;
    else if (fcs_valid)   run_q <= run_q + 1'b1;
    else                  run_q <= '0;
  end

  // R1: reset leaves a zero remainder
  p_reset_zero_r1: assert property (@(posedge clk)
    !rst_n |=> (rem_q == '0) || rst_n);

  // R2: start without a data bit leaves a zero remainder
  p_start_clear_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !bit_valid) |=> (rem_q == '0));

  // R3: no bit, no start, no shift-out: remainder holds
  p_idle_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!start && !bit_valid && !fcs_valid) |=> $stable(rem_q));

  // R5: check sequence never lasts longer than W clocks
  p_fcs_len_r5: assert property (@(posedge clk) disable iff (!rst_n)
    run_q <= RW'(W));

  // R6: during shift-out the register only loses ones, whatever bit_valid does
  p_emit_ignore_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (fcs_valid && !start) |=> ($countones(rem_q) <= $countones($past(rem_q))));

  // R7: the error flag matches the remainder left by the frame
  p_flag_match_r7: assert property (@(posedge clk) disable iff (!rst_n)
    check_done |-> (crc_error == (rem_q != '0)));

  // R8: the error flag only rises together with a check result
  p_err_rise_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(crc_error) |-> check_done);

  // R9: the error flag falls only on a start
  p_err_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(crc_error) |-> ($past(start) || $past(check_done) || check_done));

endmodule

bind crc_serial_unit crc_serial_unit_chk #(.W(FCS_W)) chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .start      (start),
  .bit_valid  (bit_valid),
  .fcs_valid  (fcs_valid),
  .crc_error  (crc_error),
  .check_done (check_done),
  .rem_q      (rem_q)
);

// File: tb/crc_serial_unit_tb_top.sv
`timescale 1ns/1ps
module crc_serial_unit_tb_top;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic [1:0] st, bv, bi, me, mc;
  logic [1:0] fb, fv, er, dn;

  crc_serial_unit dut_i (
    .clk(clk), .rst_n(rst_n), .start(st[0]), .bit_valid(bv[0]), .bit_in(bi[0]),
    .msg_end(me[0]), .mode_check(mc[0]), .fcs_bit(fb[0]), .fcs_valid(fv[0]),
    .crc_error(er[0]), .check_done(dn[0])
  );

  crc_serial_unit #(.FCS_W(12), .POLY(13'b1100000001011)) dut_w12_i (
    .clk(clk), .rst_n(rst_n), .start(st[1]), .bit_valid(bv[1]), .bit_in(bi[1]),
    .msg_end(me[1]), .mode_check(mc[1]), .fcs_bit(fb[1]), .fcs_valid(fv[1]),
    .crc_error(er[1]), .check_done(dn[1])
  );

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic int wid(input int u);
    return (u == 0) ? 5 : 12;
  endfunction

  // Long-division model: remainder of msg * 2^w divided by the unit's polynomial
  function automatic logic [63:0] ref_rem(input logic [63:0] msg, input int len, input int u);
    logic [63:0] d;
    logic [63:0] p;
    int w;
    w = wid(u);
    p = (u == 0) ? 64'b110101 : 64'b1100000001011;
    d = msg << w;
    for (int i = len + w - 1; i >= w; i--) begin
      if (d[i]) d = d ^ (p << (i - w));
    end
    return d & ((64'd1 << w) - 64'd1);
  endfunction

  task automatic idle(input int u);
    st[u] = 1'b0; bv[u] = 1'b0; me[u] = 1'b0; bi[u] = 1'b0;
  endtask

  task automatic start_pulse(input int u, input logic mode);
    @(negedge clk);
    idle(u); st[u] = 1'b1; mc[u] = mode;
    @(negedge clk);
    st[u] = 1'b0;
  endtask

  task automatic send_bits(input int u, input logic [63:0] v, input int len,
                           input bit with_end, input bit gaps);
    for (int i = len - 1; i >= 0; i--) begin
      if (gaps && (i % 3 == 0)) begin
        @(negedge clk);
        bv[u] = 1'b0; me[u] = 1'b0; bi[u] = ~v[i];
      end
      @(negedge clk);
      bv[u] = 1'b1; bi[u] = v[i]; me[u] = with_end && (i == 0);
    end
  endtask

  // Generate-mode scenario; checks value (R4), timing (R5), ignored bits (R6)
  task automatic gen_case(input int u, input logic [63:0] msg, input int len,
                          input bit gaps, input bit noise, input string req);
    logic [63:0] got;
    int nvalid;
    int w;
    w = wid(u);
    got = '0;
    nvalid = 0;
    start_pulse(u, 1'b0);
    send_bits(u, msg, len, 1'b1, gaps);
    @(negedge clk);
    idle(u);
    if (noise) begin bv[u] = 1'b1; bi[u] = 1'b1; end
    for (int i = 0; i < w; i++) begin
      if (fv[u]) nvalid++;
      got = (got << 1) | 64'(fb[u]);
      if (noise) bi[u] = ~bi[u];
      if (i < w - 1) @(negedge clk);
    end
    @(negedge clk);
    bv[u] = 1'b0;
    chk({req, " R5 fcs_valid clocks"}, 64'(nvalid), 64'(w));
    chk({req, " R5 fcs_valid low after"}, 64'(fv[u]), 64'd0);
    chk({req, noise ? " R6 fcs with busy input" : " R4 fcs value"}, got, ref_rem(msg, len, u));
  endtask

  // Check-mode scenario: frame = msg followed by its FCS, with optional flips
  task automatic chk_case(input int u, input logic [63:0] msg, input int len,
                          input logic [63:0] flip, input logic exp_err, input string req);
    logic [63:0] frame;
    int w;
    w = wid(u);
    frame = ((msg << w) | ref_rem(msg, len, u)) ^ flip;
    start_pulse(u, 1'b1);
    send_bits(u, frame, len + w, 1'b1, 1'b0);
    @(negedge clk);
    idle(u);
    chk({req, " R7 check_done pulse"}, 64'(dn[u]), 64'd1);
    chk({req, exp_err ? " R8 crc_error set" : " R7 crc_error clear"}, 64'(er[u]), 64'(exp_err));
    @(negedge clk);
    chk({req, " R7 check_done one clock"}, 64'(dn[u]), 64'd0);
    chk({req, " R9 crc_error held"}, 64'(er[u]), 64'(exp_err));
  endtask

  initial begin
    st = '0; bv = '0; bi = '0; me = '0; mc = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    for (int u = 0; u < 2; u++) begin
      chk("R1 fcs_valid", 64'(fv[u]), 64'd0);
      chk("R1 crc_error", 64'(er[u]), 64'd0);
      chk("R1 check_done", 64'(dn[u]), 64'd0);
    end

    // R4: worked example, checked against the constant and against the model
    chk("R4 model sanity", ref_rem(64'b1010001101, 10, 0), 64'b01110);
    gen_case(0, 64'b1010001101, 10, 1'b0, 1'b0, "u5 example");

    // R3: idle clocks between bits
    gen_case(0, 64'hDEADBEEF, 32, 1'b1, 1'b0, "u5 gaps R3");

    // R2: junk bits before a new start
    start_pulse(0, 1'b0);
    send_bits(0, 64'h5A5, 12, 1'b0, 1'b0);
    @(negedge clk); idle(0);
    gen_case(0, 64'h0F0F1, 20, 1'b0, 1'b0, "u5 after junk R2");

    // R6: bit_valid toggled during shift-out
    gen_case(0, 64'h3C3, 10, 1'b0, 1'b1, "u5 busy");

    // R10: degree-12 polynomial
    gen_case(1, 64'b1010001101, 10, 1'b0, 1'b0, "u12 R10");
    gen_case(1, 64'h12345678, 32, 1'b1, 1'b1, "u12 R10 gaps busy");

    // R7/R8/R9 check mode
    chk_case(0, 64'b1010001101, 10, 64'd0, 1'b0, "u5 clean");
    chk_case(0, 64'hBEEF, 16, 64'd1 << 7, 1'b1, "u5 single flip");
    chk_case(0, 64'hBEEF, 16, 64'b10011 << 2, 1'b1, "u5 burst5");
    start_pulse(0, 1'b1);
    chk("R9 start clears crc_error", 64'(er[0]), 64'd0);
    chk_case(1, 64'hCAFE1234, 32, 64'd0, 1'b0, "u12 R10 clean");
    chk_case(1, 64'hCAFE1234, 32, 64'hA01 << 6, 1'b1, "u12 R10 burst12");
    start_pulse(1, 1'b0);
    chk("R9 start clears crc_error u12", 64'(er[1]), 64'd0);

    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule